// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of 32-bit control words for a host bridge. Software reaches each word by its word index, which is the byte offset divided by four. The bank holds 28 words with indices 0 to 27. It keeps general configuration, GPIO, interrupt configuration, mailbox, cache and timing words. Every word has a fixed reset value. The hardware these words steer is outside the block.

Two words act as atomic modifiers of the interrupt enable word. A write to the set word ORs its data into the enable mask. A write to the clear word removes the written bits from the mask. Both words also keep the last value written to them. The enable word and the interrupt status word are read-only. The general configuration word has a self-reset bit. When a write moves that bit from 0 to 1, the block emits a one-cycle system reset request.

The bus is a plain register port with no handshake. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_idx`, so a word written at an edge can be read right after that edge.

Top module: `bridge_ctl_regs`

## Requirements
- R1: Index i (0..27) selects one 32-bit word. A write to an ordinary word at index i replaces its contents at the clock edge. A read at index i returns the current contents on `rd_data` in the same cycle.
- R2: After reset, these words hold non-zero values:

  | Index | Reset value |
  |-------|-------------|
  | 0 | 0x00000C40 |
  | 1 | 0x00001384 (bits 12, 9, 8, 7 and 2 set) |
  | 2 | 0x2BFF8010 |
  | 3 | 0x255E0091 |
  | 4 | 0x00006140 |
  | 7 | 0x000001FF |
  | 8 | 0x000001FF |
  | 26 | 0x00000008 |
  | 27 | 0x10000000 |

  Every other word resets to zero.
- R3: A write to index 12 (the set word) stores the data in word 12. In the same edge it ORs the data into the enable word at index 14.
- R4: A write to index 13 (the clear word) stores the data in word 13. In the same edge it clears, in word 14, every bit that is 1 in the data.
- R5: Writes to index 14 (enable) and index 15 (status) change nothing. Index 15 always reads zero.
- R6: A write to index 1 whose data has bit 2 = 1, while the stored bit 2 is 0, raises `sys_rst_req` for exactly the one cycle after that edge. The written value is still stored.
- R7: `sys_rst_req` stays low for any write that is not a 0-to-1 change of bit 2 of index 1. This includes a write with bit 2 = 1 when the stored bit is already 1.
- R8: Writes to indices 28 to 31 are dropped, and reads of those indices return zero.
- R9: `irq_en` always equals the contents of the enable word at index 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Word index of the read |
| rd_data | output | 32 | Read data, combinational |
| irq_en | output | 32 | Current interrupt enable mask |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- A set-word write leaves all of its bits set in the mask.
- A clear-word write leaves none of its bits set in the mask.
- The mask holds still when neither word is written.
- The reset request appears only after a write to the configuration word, and it never lasts two cycles.

Only the bench scenarios can show the rest:
- The exact reset image.
- The dropped writes to read-only and undefined indices.
- The request being withheld when bit 2 is already set.

These are covered by a reference model that is updated on random writes across the whole 5-bit index space.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned IDX_CFG     = 1;
  localparam int unsigned IDX_GPIO_D  = 7;
  localparam int unsigned IDX_GPIO_E  = 8;
  localparam int unsigned IDX_EN_SET  = 12;
  localparam int unsigned IDX_EN_CLR  = 13;
  localparam int unsigned IDX_EN      = 14;
  localparam int unsigned IDX_STATUS  = 15;
  localparam int unsigned SELF_RST_BIT = 2;

  // reset image of each word; words not listed are zero
  function automatic logic [31:0] reset_word(input int unsigned idx);
    case (idx)
      0:          return 32'h0000_0C40;
      IDX_CFG:    return 32'h0000_1384;
      2:          return 32'h2BFF_8010;
      3:          return 32'h255E_0091;
      4:          return 32'h0000_6140;
      IDX_GPIO_D: return 32'h0000_01FF;
      IDX_GPIO_E: return 32'h0000_01FF;
      26:         return 32'h0000_0008;
      27:         return 32'h1000_0000;
      default:    return 32'h0;
    endcase
  endfunction

  // true for words that take the write data directly
  function automatic bit plain_word(input int unsigned idx);
    return (idx != IDX_EN) && (idx != IDX_STATUS);
  endfunction
endpackage

// File: rtl/brc_word_bank.sv
module brc_word_bank #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 28
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_WORDS-1:0]             wr_hit,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [DATA_W-1:0]                en_word,
  output logic [NUM_WORDS-1:0][DATA_W-1:0] words
);
  import brc_pkg::*;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (plain_word(i)) begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= DATA_W'(reset_word(i));
        else if (wr_hit[i]) q <= wr_data;
      end
      assign words[i] = q;
    end else if (i == IDX_EN) begin : g_en
      assign words[i] = en_word;
    end else begin : g_zero
      assign words[i] = '0;
    end
  end
endmodule

// File: rtl/brc_irq_enable.sv
module brc_irq_enable #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_set,
  input  logic              do_clr,
  input  logic [DATA_W-1:0] mask_in,
  output logic [DATA_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (do_set) en_q <= en_q | mask_in;
    else if (do_clr) en_q <= en_q & ~mask_in;
  end

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> ((en_q & $past(mask_in)) == $past(mask_in)));
  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> ((en_q & $past(mask_in)) == '0));
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_set || do_clr) |=> $stable(en_q));
endmodule

// File: rtl/brc_self_reset.sv
module brc_self_reset (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic old_bit,
  input  logic new_bit,
  output logic req_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) req_pulse <= 1'b0;
    else        req_pulse <= cfg_wr && !old_bit && new_bit;
  end

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse);
  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> $past(cfg_wr));
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned NUM_WORDS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] irq_en,
  output logic              sys_rst_req
);
  import brc_pkg::*;

  logic [NUM_WORDS-1:0]             wr_hit;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]                en_q;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_dec
    assign wr_hit[i] = wr_en && (wr_idx == IDX_W'(i));
  end

  brc_word_bank #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_data(wr_data),
    .en_word(en_q), .words(words));

  brc_irq_enable #(.DATA_W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n), .do_set(wr_hit[IDX_EN_SET]),
    .do_clr(wr_hit[IDX_EN_CLR]), .mask_in(wr_data), .en_q(en_q));

  brc_self_reset u_srst (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr_hit[IDX_CFG]),
    .old_bit(words[IDX_CFG][SELF_RST_BIT]),
    .new_bit(wr_data[SELF_RST_BIT]), .req_pulse(sys_rst_req));

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (rd_idx == IDX_W'(k)) rd_data = words[k];
  end

  assign irq_en = en_q;

  // R8
  undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= NUM_WORDS) |-> (rd_data == '0));
  // R5
  status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IDX_W'(IDX_STATUS)) |-> (rd_data == '0));
endmodule

// File: tb/test_bridge_ctl_regs.sv
module test_bridge_ctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data, irq_en;
  logic        sys_rst_req;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] mdl [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_ctl_regs i_bridge_ctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .irq_en(irq_en), .sys_rst_req(sys_rst_req));

  function automatic logic [31:0] exp_reset(input int idx);
    case (idx)
      0: return 32'h0000_0C40;  1: return 32'h0000_1384;
      2: return 32'h2BFF_8010;  3: return 32'h255E_0091;
      4: return 32'h0000_6140;  7: return 32'h0000_01FF;
      8: return 32'h0000_01FF; 26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit exp_pulse(input int idx, input logic [31:0] old1,
                                   input logic [31:0] d);
    return (idx == 1) && !old1[2] && d[2];
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input int idx);
    rd_idx = 5'(idx);
    #1;
    check(req, rd_data, mdl[idx]);
  endtask

  // drive at negedge, write at posedge, check at the following negedge
  task automatic do_write(input int idx, input logic [31:0] d);
    bit p;
    p = exp_pulse(idx, mdl[1], d);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 28 && idx != 14 && idx != 15) mdl[idx] = d;
    if (idx == 12) mdl[14] = mdl[14] | d;
    if (idx == 13) mdl[14] = mdl[14] & ~d;
    check(idx == 1 ? "R6" : "R7", 32'(sys_rst_req), 32'(p));
    check("R9", irq_en, mdl[14]);
    read_chk(idx >= 28 ? "R8" : (idx >= 12 && idx <= 15) ? "R5" : "R1", idx);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) mdl[i] = exp_reset(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset image, R8 undefined, R5 status
    for (int i = 0; i < 32; i++) read_chk(i >= 28 ? "R8" : "R2", i);
    check("R2", 32'(sys_rst_req), 32'd0);
    // R7: bit 2 already 1 after reset -> no pulse
    do_write(1, 32'h0000_1384);
    // R6: clear then raise bit 2
    do_write(1, 32'h0);
    do_write(1, 32'hA5A5_0004);
    @(negedge clk);
    check("R6", 32'(sys_rst_req), 32'd0);
    // R3/R4 enable set and clear
    do_write(12, 32'h0000_00F0);
    do_write(12, 32'h8000_0001);
    do_write(13, 32'h0000_0030);
    // R5 read-only words
    do_write(14, 32'hFFFF_FFFF);
    do_write(15, 32'h1234_5678);
    // R8 undefined indices
    do_write(29, 32'hDEAD_BEEF);
    do_write(31, 32'hFFFF_FFFF);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int idx;
      logic [31:0] d;
      idx = ($urandom % 4 == 0) ? (($urandom % 2 == 0) ? 1 : 12 + int'($urandom % 4))
                                : int'($urandom % 32);
      d = $urandom;
      do_write(idx, d);
      read_chk("R1", int'($urandom % 32));
    end
    for (int i = 0; i < 32; i++) read_chk("R1", i);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule